// File: doc/BRIEF.md
# Byte-Parity RAM with Byte Enables

This block is a synchronous single-port memory whose data word is split into 8-bit byte lanes. Each lane is stored as a 9-bit slot: the byte and one extra bit. A configuration input picks what the extra bit means. In parity mode the block fills it with even parity over the byte and checks it on every read, raising one error flag per lane. In user mode the caller supplies the bit on a per-lane tag input, the block stores it unchanged, and it is never checked. Writes are masked lane by lane with byte enables. A masked lane keeps both its byte and its extra bit.

The storage is built as two half-size banks. In unified mode the primary port (A) sees the whole address space, and its top address bit picks the bank. In split mode the array serves as two independent half-size memories. Port A reaches the lower bank and its top address bit is ignored. Port B, which has its own address, enables and data, reaches the upper bank. Both ports can access their banks in the same cycle.

Reads are registered and read-first. Data, tags and error flags appear together one clock after the address. The mode inputs are sampled with that address.

Top module: `bpr_ram`

## Requirements
- R1: While reset is asserted and right after it, every read output of both ports (data, tags, error flags) is zero.
- R2: The data and tag of the word addressed at a clock edge appear on the outputs after that edge and stay there until the next edge. A write in the same cycle returns the word's previous contents (read-first).
- R3: A write stores lane i (data bits 8i+7..8i, tag bit i) only when byte enable bit i is 1. A lane whose enable is 0 keeps its byte and its extra bit.
- R4: With par_mode_i = 1, each written lane's extra bit becomes the XOR of its 8 data bits (even parity over 9 bits). On a read, error flag i is 1 exactly when the XOR of the 9 stored bits of lane i is 1. par_mode_i is taken in the cycle the address is presented.
- R5: With par_mode_i = 0, each written lane's extra bit is the corresponding bit of the tag input, and every error flag reads 0.
- R6: The tag output always shows the stored extra bit of each lane, in either mode.
- R7: A lane stored in user mode with an extra bit different from its byte's parity is flagged when it is read in parity mode. Only that lane is flagged.
- R8: With split_i = 0, port A's full address reaches all words, and its top bit selects the upper half. Writes from port B have no effect, and port B's read outputs are zero.
- R9: With split_i = 1, port A uses only the low ADDR_W-1 address bits on the lower half, and port B uses b_addr_i on the upper half. Both ports read and write in the same cycle without affecting each other.
- R10: A write in which a lane's enable is 0 never changes that lane's error flag on later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| split_i | input | 1 | 1 = two independent half memories, 0 = one memory on port A |
| par_mode_i | input | 1 | 1 = extra bit is generated/checked parity, 0 = extra bit is user data |
| a_addr_i | input | ADDR_W (9) | Port A word address |
| a_we_i | input | 1 | Port A write enable |
| a_be_i | input | BYTES (2) | Port A byte enables, bit i for lane i |
| a_wdata_i | input | 8*BYTES (16) | Port A write data |
| a_wtag_i | input | BYTES (2) | Port A user extra bits (used in user mode) |
| a_rdata_o | output | 8*BYTES (16) | Port A read data |
| a_rtag_o | output | BYTES (2) | Port A stored extra bits |
| a_perr_o | output | BYTES (2) | Port A per-lane parity error flags |
| b_addr_i | input | ADDR_W-1 (8) | Port B word address (split mode) |
| b_we_i | input | 1 | Port B write enable |
| b_be_i | input | BYTES (2) | Port B byte enables |
| b_wdata_i | input | 8*BYTES (16) | Port B write data |
| b_wtag_i | input | BYTES (2) | Port B user extra bits |
| b_rdata_o | output | 8*BYTES (16) | Port B read data |
| b_rtag_o | output | BYTES (2) | Port B stored extra bits |
| b_perr_o | output | BYTES (2) | Port B per-lane parity error flags |

## Verification
All results are due exactly one rising edge after the inputs that cause them. This covers read data, tags and error flags, and the zero outputs of port B in unified mode. A write's new contents first show when the same word is presented again at a later edge. The driver applies each stimulus on a falling edge and computes the result expected at the next rising edge from a word-level model. Because the memory is read-first, it computes that result before the model takes the write. The monitor takes each item from the queue a short delay after that rising edge and compares it, so every comparison lands in the cycle where the result is due.

// File: rtl/bpr_pkg.sv
package bpr_pkg;

    localparam int LANE_BITS = 8;
    localparam int SLOT_BITS = LANE_BITS + 1;

    typedef enum logic {
        TAG_USER   = 1'b0,
        TAG_PARITY = 1'b1
    } tag_mode_e;

    typedef enum logic {
        MAP_UNIFIED = 1'b0,
        MAP_SPLIT   = 1'b1
    } map_mode_e;

    function automatic logic even_bit(input logic [LANE_BITS-1:0] b);
        return ^b;
    endfunction

endpackage

// File: rtl/bpr_lane_enc.sv
module bpr_lane_enc
    import bpr_pkg::*;
#(
    parameter int BYTES = 2
) (
    input  logic                          mode,
    input  logic [BYTES*LANE_BITS-1:0]    wdata,
    input  logic [BYTES-1:0]              wtag,
    output logic [BYTES*SLOT_BITS-1:0]    slots
);

    tag_mode_e m;
    assign m = tag_mode_e'(mode);

    // Each slot: extra bit on top, byte below.
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [LANE_BITS-1:0] byte_w;
        logic                 extra_w;
        assign byte_w  = wdata[g*LANE_BITS +: LANE_BITS];
        assign extra_w = (m == TAG_PARITY) ? even_bit(byte_w) : wtag[g];
        assign slots[g*SLOT_BITS +: SLOT_BITS] = {extra_w, byte_w};
    end

endmodule

// File: rtl/bpr_lane_chk.sv
module bpr_lane_chk
    import bpr_pkg::*;
#(
    parameter int BYTES = 2
) (
    input  logic                          mode,
    input  logic [BYTES*SLOT_BITS-1:0]    slots,
    output logic [BYTES*LANE_BITS-1:0]    rdata,
    output logic [BYTES-1:0]              rtag,
    output logic [BYTES-1:0]              perr
);

    tag_mode_e m;
    assign m = tag_mode_e'(mode);

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [SLOT_BITS-1:0] slot_r;
        assign slot_r = slots[g*SLOT_BITS +: SLOT_BITS];
        assign rdata[g*LANE_BITS +: LANE_BITS] = slot_r[LANE_BITS-1:0];
        assign rtag[g] = slot_r[LANE_BITS];
        assign perr[g] = (m == TAG_PARITY) && (^slot_r);
    end

endmodule

// File: rtl/bpr_bank.sv
module bpr_bank
    import bpr_pkg::*;
#(
    parameter int BYTES  = 2,
    parameter int ADDR_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          we,
    input  logic [BYTES-1:0]              be,
    input  logic [BYTES*SLOT_BITS-1:0]    wword,
    output logic [BYTES*SLOT_BITS-1:0]    rword
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int SW    = BYTES * SLOT_BITS;

    logic [SW-1:0] mem [DEPTH];

    // Masked write: only enabled slots are touched.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < BYTES; i++) begin
                if (be[i]) begin
                    mem[addr][i*SLOT_BITS +: SLOT_BITS] <= wword[i*SLOT_BITS +: SLOT_BITS];
                end
            end
        end
    end

    // Registered read-first output.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rword <= '0;
        end else begin
            rword <= mem[addr];
        end
    end

    // Warm-up counter so two-deep history is only used once it exists.
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    for (genvar g = 0; g < BYTES; g++) begin : g_chk
        AST_MASKED_SLOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q >= 2'd2 && $past(we, 2) && !$past(be[g], 2) && ($past(addr, 2) == $past(addr, 1)))
            |-> (rword[g*SLOT_BITS +: SLOT_BITS] == $past(rword[g*SLOT_BITS +: SLOT_BITS]))); // R3
        AST_WRITTEN_SLOT_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q >= 2'd2 && $past(we, 2) && $past(be[g], 2) && ($past(addr, 2) == $past(addr, 1)))
            |-> (rword[g*SLOT_BITS +: SLOT_BITS] == $past(wword[g*SLOT_BITS +: SLOT_BITS], 2))); // R2
    end

endmodule

// File: rtl/bpr_ram.sv
module bpr_ram
    import bpr_pkg::*;
#(
    parameter int BYTES  = 2,
    parameter int ADDR_W = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       split_i,
    input  logic                       par_mode_i,
    input  logic [ADDR_W-1:0]          a_addr_i,
    input  logic                       a_we_i,
    input  logic [BYTES-1:0]           a_be_i,
    input  logic [BYTES*8-1:0]         a_wdata_i,
    input  logic [BYTES-1:0]           a_wtag_i,
    output logic [BYTES*8-1:0]         a_rdata_o,
    output logic [BYTES-1:0]           a_rtag_o,
    output logic [BYTES-1:0]           a_perr_o,
    input  logic [ADDR_W-2:0]          b_addr_i,
    input  logic                       b_we_i,
    input  logic [BYTES-1:0]           b_be_i,
    input  logic [BYTES*8-1:0]         b_wdata_i,
    input  logic [BYTES-1:0]           b_wtag_i,
    output logic [BYTES*8-1:0]         b_rdata_o,
    output logic [BYTES-1:0]           b_rtag_o,
    output logic [BYTES-1:0]           b_perr_o
);

    localparam int HAW    = ADDR_W - 1;
    localparam int SW     = BYTES * SLOT_BITS;
    localparam int NBANKS = 2;

    map_mode_e map_now;
    assign map_now = map_mode_e'(split_i);

    // Encode write words for both ports.
    logic [SW-1:0] enc_a, enc_b;

    bpr_lane_enc #(.BYTES(BYTES)) u_enc_a (
        .mode  (par_mode_i),
        .wdata (a_wdata_i),
        .wtag  (a_wtag_i),
        .slots (enc_a)
    );

    bpr_lane_enc #(.BYTES(BYTES)) u_enc_b (
        .mode  (par_mode_i),
        .wdata (b_wdata_i),
        .wtag  (b_wtag_i),
        .slots (enc_b)
    );

    // Bank routing.
    logic             a_upper;
    logic [HAW-1:0]   bk_addr  [NBANKS];
    logic             bk_we    [NBANKS];
    logic [BYTES-1:0] bk_be    [NBANKS];
    logic [SW-1:0]    bk_wword [NBANKS];
    logic [SW-1:0]    bk_rword [NBANKS];

    assign a_upper = a_addr_i[HAW];

    always_comb begin
        bk_addr[0]  = a_addr_i[HAW-1:0];
        bk_be[0]    = a_be_i;
        bk_wword[0] = enc_a;
        bk_addr[1]  = a_addr_i[HAW-1:0];
        bk_be[1]    = a_be_i;
        bk_wword[1] = enc_a;
        unique case (map_now)
            MAP_SPLIT: begin
                bk_we[0]    = a_we_i;
                bk_addr[1]  = b_addr_i;
                bk_we[1]    = b_we_i;
                bk_be[1]    = b_be_i;
                bk_wword[1] = enc_b;
            end
            MAP_UNIFIED: begin
                bk_we[0] = a_we_i && !a_upper;
                bk_we[1] = a_we_i && a_upper;
            end
            default: begin
                bk_we[0] = 1'b0;
                bk_we[1] = 1'b0;
            end
        endcase
    end

    for (genvar k = 0; k < NBANKS; k++) begin : g_bank
        bpr_bank #(.BYTES(BYTES), .ADDR_W(HAW)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .addr  (bk_addr[k]),
            .we    (bk_we[k]),
            .be    (bk_be[k]),
            .wword (bk_wword[k]),
            .rword (bk_rword[k])
        );
    end

    // Read-side context captured with the address.
    map_mode_e map_q;
    tag_mode_e mode_q;
    logic      upper_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q   <= MAP_UNIFIED;
            mode_q  <= TAG_USER;
            upper_q <= 1'b0;
        end else begin
            map_q   <= map_now;
            mode_q  <= tag_mode_e'(par_mode_i);
            upper_q <= a_upper;
        end
    end

    logic [SW-1:0] word_a, word_b;

    always_comb begin
        unique case (map_q)
            MAP_SPLIT: begin
                word_a = bk_rword[0];
                word_b = bk_rword[1];
            end
            MAP_UNIFIED: begin
                word_a = upper_q ? bk_rword[1] : bk_rword[0];
                word_b = '0;
            end
            default: begin
                word_a = '0;
                word_b = '0;
            end
        endcase
    end

    bpr_lane_chk #(.BYTES(BYTES)) u_chk_a (
        .mode  (mode_q == TAG_PARITY),
        .slots (word_a),
        .rdata (a_rdata_o),
        .rtag  (a_rtag_o),
        .perr  (a_perr_o)
    );

    bpr_lane_chk #(.BYTES(BYTES)) u_chk_b (
        .mode  (mode_q == TAG_PARITY),
        .slots (word_b),
        .rdata (b_rdata_o),
        .rtag  (b_rtag_o),
        .perr  (b_perr_o)
    );

    AST_USER_MODE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(par_mode_i) |-> (a_perr_o == '0 && b_perr_o == '0)); // R5
    AST_UNIFIED_B_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(split_i) |-> (b_rdata_o == '0 && b_rtag_o == '0 && b_perr_o == '0)); // R8

endmodule

// File: tb/tb_bpr_ram.sv
module tb_bpr_ram;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        split_i = 1'b0, par_mode_i = 1'b1;
    logic [8:0]  a_addr_i = '0;
    logic        a_we_i = 1'b0;
    logic [1:0]  a_be_i = '0;
    logic [15:0] a_wdata_i = '0;
    logic [1:0]  a_wtag_i = '0;
    logic [15:0] a_rdata_o;
    logic [1:0]  a_rtag_o, a_perr_o;
    logic [7:0]  b_addr_i = '0;
    logic        b_we_i = 1'b0;
    logic [1:0]  b_be_i = '0;
    logic [15:0] b_wdata_i = '0;
    logic [1:0]  b_wtag_i = '0;
    logic [15:0] b_rdata_o;
    logic [1:0]  b_rtag_o, b_perr_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    bpr_ram dut (.*);

    typedef struct {
        bit          ca;
        logic [15:0] ad;
        logic [1:0]  at, ap;
        bit          cb;
        logic [15:0] bd;
        logic [1:0]  bt, bp;
        string       req;
    } exp_t;

    exp_t q[$];
    logic [17:0] m [512];
    bit ok [512];

    task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic void expect_word(input logic [17:0] w, input bit md,
                                        output logic [15:0] d, output logic [1:0] t, output logic [1:0] p);
        for (int i = 0; i < 2; i++) begin
            d[i*8 +: 8] = w[i*9 +: 8];
            t[i] = w[i*9 + 8];
            p[i] = md ? ^w[i*9 +: 9] : 1'b0;
        end
    endfunction

    function automatic void model_write(input int idx, input bit md, input logic [1:0] be,
                                        input logic [15:0] wd, input logic [1:0] wt);
        for (int i = 0; i < 2; i++) begin
            if (be[i]) m[idx][i*9 +: 9] = {md ? ^wd[i*8 +: 8] : wt[i], wd[i*8 +: 8]};
        end
        if (be == 2'b11) ok[idx] = 1'b1;
    endfunction

    task automatic step(input bit sp, input bit md,
                        input logic [8:0] aa, input bit aw, input logic [1:0] abe,
                        input logic [15:0] awd, input logic [1:0] awt,
                        input logic [7:0] ba, input bit bw, input logic [1:0] bbe,
                        input logic [15:0] bwd, input logic [1:0] bwt, input string req);
        exp_t e;
        int ia, ib;
        @(negedge clk);
        split_i = sp; par_mode_i = md;
        a_addr_i = aa; a_we_i = aw; a_be_i = abe; a_wdata_i = awd; a_wtag_i = awt;
        b_addr_i = ba; b_we_i = bw; b_be_i = bbe; b_wdata_i = bwd; b_wtag_i = bwt;
        ia = sp ? {1'b0, aa[7:0]} : int'(aa);
        ib = {1'b1, ba};
        e.req = req;
        e.ca = ok[ia];
        expect_word(m[ia], md, e.ad, e.at, e.ap);
        if (sp) begin
            e.cb = ok[ib];
            expect_word(m[ib], md, e.bd, e.bt, e.bp);
        end else begin
            e.cb = 1'b1;
            e.bd = '0; e.bt = '0; e.bp = '0;
        end
        q.push_back(e);
        if (aw) model_write(ia, md, abe, awd, awt);
        if (sp && bw) model_write(ib, md, bbe, bwd, bwt);
    endtask

    task automatic wr_a(input bit sp, input bit md, input logic [8:0] aa, input logic [1:0] be,
                        input logic [15:0] wd, input logic [1:0] wt, input string req);
        step(sp, md, aa, 1'b1, be, wd, wt, 8'h0, 1'b0, 2'b00, 16'h0, 2'b00, req);
    endtask

    task automatic rd_a(input bit sp, input bit md, input logic [8:0] aa, input string req);
        step(sp, md, aa, 1'b0, 2'b00, 16'h0, 2'b00, 8'h0, 1'b0, 2'b00, 16'h0, 2'b00, req);
    endtask

    // Monitor: compares each expected item just after the edge that produces it.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            if (e.ca) begin
                cmp(e.req, "a_rdata", 32'(a_rdata_o), 32'(e.ad));
                cmp(e.req, "a_rtag", 32'(a_rtag_o), 32'(e.at));
                cmp(e.req, "a_perr", 32'(a_perr_o), 32'(e.ap));
            end
            if (e.cb) begin
                cmp(e.req, "b_rdata", 32'(b_rdata_o), 32'(e.bd));
                cmp(e.req, "b_rtag", 32'(b_rtag_o), 32'(e.bt));
                cmp(e.req, "b_perr", 32'(b_perr_o), 32'(e.bp));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) begin
            m[i] = '0;
            ok[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        cmp("R1", "a_rdata", 32'(a_rdata_o), 32'h0);
        cmp("R1", "a_rtag", 32'(a_rtag_o), 32'h0);
        cmp("R1", "a_perr", 32'(a_perr_o), 32'h0);
        cmp("R1", "b_rdata", 32'(b_rdata_o), 32'h0);
        cmp("R1", "b_rtag", 32'(b_rtag_o), 32'h0);
        cmp("R1", "b_perr", 32'(b_perr_o), 32'h0);
        rst_n = 1'b1;

        // R4 R8: fill low and high regions in parity mode, unified map
        for (int i = 0; i < 16; i++) begin
            wr_a(1'b0, 1'b1, 9'(i), 2'b11, 16'hA5C3 ^ 16'(i * 16'h1357), 2'b00, "R4");
            wr_a(1'b0, 1'b1, 9'(256 + i), 2'b11, 16'h3C96 ^ 16'(i * 16'h0F21), 2'b00, "R8");
        end
        for (int i = 0; i < 16; i++) begin
            rd_a(1'b0, 1'b1, 9'(i), "R2 R4 R6");
            rd_a(1'b0, 1'b1, 9'(256 + i), "R8 R6");
        end

        // R2: read-first on a write, then new contents
        wr_a(1'b0, 1'b1, 9'd3, 2'b11, 16'h1234, 2'b00, "R2");
        rd_a(1'b0, 1'b1, 9'd3, "R2");

        // R3: byte-enable masking
        wr_a(1'b0, 1'b1, 9'd4, 2'b01, 16'hFFFF, 2'b00, "R3");
        rd_a(1'b0, 1'b1, 9'd4, "R3");
        wr_a(1'b0, 1'b1, 9'd4, 2'b10, 16'h8000, 2'b00, "R3");
        rd_a(1'b0, 1'b1, 9'd4, "R3");
        wr_a(1'b0, 1'b1, 9'd4, 2'b00, 16'h0000, 2'b11, "R3");
        rd_a(1'b0, 1'b1, 9'd4, "R3");

        // R5 R6 R7: user bits stored, lane 0 mismatched against parity
        wr_a(1'b0, 1'b0, 9'd5, 2'b11, 16'h0301, 2'b00, "R5");
        rd_a(1'b0, 1'b0, 9'd5, "R5 R6");
        rd_a(1'b0, 1'b1, 9'd5, "R7");
        wr_a(1'b0, 1'b0, 9'd6, 2'b11, 16'h0301, 2'b11, "R6");
        rd_a(1'b0, 1'b1, 9'd6, "R7");

        // R10: masked lane 0 keeps its error flag
        wr_a(1'b0, 1'b1, 9'd5, 2'b10, 16'h7700, 2'b11, "R10");
        rd_a(1'b0, 1'b1, 9'd5, "R10");
        wr_a(1'b0, 1'b0, 9'd5, 2'b10, 16'h0100, 2'b11, "R10");
        rd_a(1'b0, 1'b1, 9'd5, "R10");

        // R8: port B writes ignored in unified mode
        step(1'b0, 1'b1, 9'd262, 1'b0, 2'b00, 16'h0, 2'b00, 8'd6, 1'b1, 2'b11, 16'hBEEF, 2'b11, "R8");
        rd_a(1'b0, 1'b1, 9'd262, "R8");

        // R9: split map, simultaneous independent writes, port A top bit ignored
        step(1'b1, 1'b1, 9'h107, 1'b1, 2'b11, 16'hC0DE, 2'b00, 8'd7, 1'b1, 2'b11, 16'hFACE, 2'b00, "R9");
        step(1'b1, 1'b1, 9'h007, 1'b0, 2'b00, 16'h0, 2'b00, 8'd7, 1'b0, 2'b00, 16'h0, 2'b00, "R9");
        rd_a(1'b0, 1'b1, 9'd7, "R9");
        rd_a(1'b0, 1'b1, 9'd263, "R9");

        // Mixed traffic: R2 R3 R4 R5 R9
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], r[1], {r[2], 4'b0000, r[6:3]}, r[7], r[9:8], r[25:10], r[27:26],
                 {4'b0000, r[31:28]}, r[12], r[14:13], ~r[25:10], r[17:16], "R2 R3 R4 R5 R9");
        end

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule